// File: doc/BRIEF.md
# TDMA Slot Interrupt Generator

This block provides the periodic timing interrupts that pace a TDMA frame once slot synchronisation exists. A one-cycle sync strobe starts a slot counter. From then on the block raises a slot interrupt at the start of every slot. One slot lasts 30 ms, which is 294,912 cycles of a 9.8304 MHz system clock. Slots alternate between transmit and receive. The first slot after a sync strobe is a transmit slot.

Two switch interrupts tell the controller when to retune the RF path. The transmit-switch interrupt belongs to transmit slots and the receive-switch interrupt belongs to receive slots. Each has its own advance value, counted in system clocks, which moves it ahead of the boundary of the slot it belongs to. The block clamps each advance to one slot minus one clock. It latches both advances only at a sync strobe or a slot boundary.

Every interrupt output is an active-low pulse three clocks wide. A reset or a sync-clear strobe stops the counter and returns all outputs high.

Top module: `tdma_irq_gen`

## Requirements
- R1: After reset, and until the first `sync_start`, all three interrupt outputs stay high.
- R2: Slot cycles count 0 to SLOT_CYCLES-1. A slot event occurs in every cycle whose count is 0. The first such cycle is the one right after the `sync_start` edge.
- R3: Each event in cycle h drives its output low in cycles h+1, h+2 and h+3 only. If events come in consecutive cycles, the low periods merge.
- R4: Slots alternate kind, and slot 0 after sync is a transmit slot (slot kind encoded 0 = transmit, 1 = receive). With an advance of 0, the transmit event falls in count 0 of each transmit slot.
- R5: With an advance of 0, the receive event falls in count 0 of each receive slot.
- R6: With an advance A in the range 1 to SLOT_CYCLES-1, the switch event for a slot falls at count SLOT_CYCLES-A of the previous slot. A transmit event whose instant would lie before the sync is not produced.
- R7: An advance value of SLOT_CYCLES or more acts as SLOT_CYCLES-1.
- R8: The block samples the advance inputs only at the `sync_start` edge and at the edge where the count wraps to 0. Changes made between those edges have no effect until the next one.
- R9: A `sync_clear` (or `rst`) edge stops counting and forces all outputs high from the next cycle. This holds even if a pulse is in progress, and `sync_clear` wins over `sync_start`.
- R10: A `sync_start` while running restarts the count at 0 in a transmit slot. Pulses already started run to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_start | input | 1 | One-cycle strobe: slot synchronisation established, count restarts |
| sync_clear | input | 1 | One-cycle strobe: synchronisation lost, interrupts stop |
| tx_adv | input | ADV_W | Transmit-switch advance in clocks |
| rx_adv | input | ADV_W | Receive-switch advance in clocks |
| slot_irq_n | output | 1 | Slot interrupt, active low |
| tx_irq_n | output | 1 | Transmit-switch interrupt, active low |
| rx_irq_n | output | 1 | Receive-switch interrupt, active low |

## Verification
The pulse-width assertions assume that a new event for the same output does not arrive while its pulse is still low, except back-to-back retriggers. The slot length guarantees this for the slot interrupt. For the switch interrupts it can only fail at an advance change or a resync. The mutual-exclusion assertion relies on the transmit and receive events falling in different slot kinds or counts, which holds for any clamped advance.

The stimulus runs a short slot length so that many boundaries pass. It drives advances across the full input width, including values above the clamp. It issues sync and clear strobes, including ones that overlap, at random cycles.

// File: rtl/tdma_irq_pkg.sv
package tdma_irq_pkg;

    // 30 ms at a 9.8304 MHz system clock
    localparam int unsigned SLOT_CYCLES_DEFAULT = 294912;
    localparam int unsigned PULSE_CYCLES        = 3;
    localparam int unsigned IRQ_COUNT           = 3;

    typedef enum logic {
        SLOT_TX = 1'b0,
        SLOT_RX = 1'b1
    } slot_kind_e;

    // bit 0 slot, bit 1 transmit switch, bit 2 receive switch
    typedef struct packed {
        logic rx;
        logic tx;
        logic slot;
    } irq_vec_t;

    // Zero advance: fire on count 0 of an owned slot.
    // Non-zero advance: fire at the lead count inside the slot before an owned one.
    function automatic logic switch_hit(input logic zero_adv,
                                        input logic at_start,
                                        input logic at_lead,
                                        input logic own_slot);
        return zero_adv ? (at_start && own_slot) : (at_lead && !own_slot);
    endfunction

endpackage

// File: rtl/tdma_slot_timer.sv
module tdma_slot_timer
    import tdma_irq_pkg::*;
#(
    parameter int unsigned SLOT_CYCLES = SLOT_CYCLES_DEFAULT,
    parameter int unsigned CNT_W       = $clog2(SLOT_CYCLES),
    parameter int unsigned ADV_W       = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_start,
    input  logic             sync_clear,
    input  logic [ADV_W-1:0] tx_adv_in,
    input  logic [ADV_W-1:0] rx_adv_in,
    output logic             running,
    output slot_kind_e       kind,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] tx_adv_eff,
    output logic [CNT_W-1:0] rx_adv_eff
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SLOT_CYCLES - 1);

    function automatic logic [CNT_W-1:0] clamp_adv(input logic [ADV_W-1:0] a);
        if (int'(a) >= int'(SLOT_CYCLES)) return LAST_CNT;
        return CNT_W'(a);
    endfunction

    logic wrap;
    assign wrap = running && (cnt == LAST_CNT);

    always_ff @(posedge clk) begin
        if (rst || sync_clear) begin
            running    <= 1'b0;
            cnt        <= '0;
            kind       <= SLOT_TX;
            tx_adv_eff <= '0;
            rx_adv_eff <= '0;
        end else if (sync_start) begin
            running    <= 1'b1;
            cnt        <= '0;
            kind       <= SLOT_TX;
            tx_adv_eff <= clamp_adv(tx_adv_in);
            rx_adv_eff <= clamp_adv(rx_adv_in);
        end else if (wrap) begin
            cnt        <= '0;
            kind       <= (kind == SLOT_TX) ? SLOT_RX : SLOT_TX;
            tx_adv_eff <= clamp_adv(tx_adv_in);
            rx_adv_eff <= clamp_adv(rx_adv_in);
        end else if (running) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_SYNC_START: assert property (@(posedge clk) disable iff (rst)
        (sync_start && !sync_clear) |=> (running && cnt == '0 && kind == SLOT_TX)); // R10
    AST_WRAP_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (wrap && !sync_start && !sync_clear) |=> (cnt == '0 && kind != $past(kind))); // R4
    AST_ADV_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sync_start && !sync_clear && !wrap) |=> ($stable(tx_adv_eff) && $stable(rx_adv_eff))); // R8
    AST_ADV_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (int'(tx_adv_eff) < int'(SLOT_CYCLES)) && (int'(rx_adv_eff) < int'(SLOT_CYCLES))); // R7

endmodule

// File: rtl/tdma_irq_pulse.sv
module tdma_irq_pulse
    import tdma_irq_pkg::*;
#(
    parameter int unsigned LEN = PULSE_CYCLES
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic fire,
    output logic irq_n
);

    localparam int unsigned RW = $clog2(LEN + 1);

    logic [RW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            remain <= '0;
        end else if (fire) begin
            remain <= RW'(LEN);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign irq_n = (remain == '0);

    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst || clear)
        $fell(irq_n) |=> !irq_n); // R3
    AST_CLEAR_HIGH: assert property (@(posedge clk) disable iff (rst)
        clear |=> irq_n); // R9

endmodule

// File: rtl/tdma_irq_gen.sv
module tdma_irq_gen
    import tdma_irq_pkg::*;
#(
    parameter int unsigned SLOT_CYCLES = SLOT_CYCLES_DEFAULT,
    parameter int unsigned CNT_W       = $clog2(SLOT_CYCLES),
    parameter int unsigned ADV_W       = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_start,
    input  logic             sync_clear,
    input  logic [ADV_W-1:0] tx_adv,
    input  logic [ADV_W-1:0] rx_adv,
    output logic             slot_irq_n,
    output logic             tx_irq_n,
    output logic             rx_irq_n
);

    // Modular subtraction gives SLOT_CYCLES - adv even when SLOT_CYCLES == 2**CNT_W
    localparam logic [CNT_W-1:0] SLOT_MOD = CNT_W'(SLOT_CYCLES);

    logic             running;
    slot_kind_e       kind;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] tx_eff;
    logic [CNT_W-1:0] rx_eff;

    tdma_slot_timer #(
        .SLOT_CYCLES (SLOT_CYCLES),
        .CNT_W       (CNT_W),
        .ADV_W       (ADV_W)
    ) timer_i (
        .clk        (clk),
        .rst        (rst),
        .sync_start (sync_start),
        .sync_clear (sync_clear),
        .tx_adv_in  (tx_adv),
        .rx_adv_in  (rx_adv),
        .running    (running),
        .kind       (kind),
        .cnt        (cnt),
        .tx_adv_eff (tx_eff),
        .rx_adv_eff (rx_eff)
    );

    logic     at_start;
    irq_vec_t hit;

    assign at_start = (cnt == '0);

    always_comb begin
        hit.slot = running && at_start;
        hit.tx   = running && switch_hit(tx_eff == '0, at_start,
                                         cnt == (SLOT_MOD - tx_eff), kind == SLOT_TX);
        hit.rx   = running && switch_hit(rx_eff == '0, at_start,
                                         cnt == (SLOT_MOD - rx_eff), kind == SLOT_RX);
    end

    logic [IRQ_COUNT-1:0] fire_vec;
    logic [IRQ_COUNT-1:0] irq_n_vec;

    assign fire_vec = hit;

    for (genvar i = 0; i < IRQ_COUNT; i++) begin : g_pulse
        tdma_irq_pulse #(
            .LEN (PULSE_CYCLES)
        ) pulse_i (
            .clk   (clk),
            .rst   (rst),
            .clear (sync_clear),
            .fire  (fire_vec[i]),
            .irq_n (irq_n_vec[i])
        );
    end

    assign slot_irq_n = irq_n_vec[0];
    assign tx_irq_n   = irq_n_vec[1];
    assign rx_irq_n   = irq_n_vec[2];

    AST_SWITCH_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(hit.tx && hit.rx)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !running |-> (fire_vec == '0)); // R1

endmodule

// File: tb/tdma_irq_gen_tb_top.sv
`timescale 1ns/1ps
module tdma_irq_gen_tb_top;

    localparam int S  = 12;
    localparam int CW = 4;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sync_start = 1'b0;
    logic          sync_clear = 1'b0;
    logic [AW-1:0] tx_adv = '0;
    logic [AW-1:0] rx_adv = '0;
    logic          slot_irq_n, tx_irq_n, rx_irq_n;

    always #4 clk = ~clk;

    tdma_irq_gen #(.SLOT_CYCLES(S), .CNT_W(CW), .ADV_W(AW)) dut_i (
        .clk (clk), .rst (rst), .sync_start (sync_start), .sync_clear (sync_clear),
        .tx_adv (tx_adv), .rx_adv (rx_adv),
        .slot_irq_n (slot_irq_n), .tx_irq_n (tx_irq_n), .rx_irq_n (rx_irq_n)
    );

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string phase = "R1_reset";

    // reference model state
    bit       m_run = 0;
    int       m_cnt = 0;
    bit       m_odd = 0;
    int       m_ltx = 0;
    int       m_lrx = 0;
    bit [2:0] h_slot = '0, h_tx = '0, h_rx = '0;

    function automatic int clampv(input int a);
        return (a >= S) ? S - 1 : a;
    endfunction

    function automatic bit sw_hit(input int adv, input bit own);
        if (adv == 0) return (m_cnt == 0) && own;
        return (m_cnt == S - adv) && !own;
    endfunction

    task automatic check1(input string req, input string nm, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s %s got=%b exp=%b t=%0t", phase, req, nm, got, exp, $time);
        end
    endtask

    task automatic step(input bit i_rst, input bit i_ss, input bit i_sc,
                        input int i_atx, input int i_arx);
        bit hs, ht, hr;
        @(negedge clk);
        check1("R2,R3", "slot_irq_n", slot_irq_n, !(|h_slot));
        check1("R4,R3", "tx_irq_n",   tx_irq_n,   !(|h_tx));
        check1("R5,R3", "rx_irq_n",   rx_irq_n,   !(|h_rx));
        hs = m_run && (m_cnt == 0);
        ht = m_run && sw_hit(m_ltx, !m_odd);
        hr = m_run && sw_hit(m_lrx, m_odd);
        rst        = i_rst;
        sync_start = i_ss;
        sync_clear = i_sc;
        tx_adv     = AW'(i_atx);
        rx_adv     = AW'(i_arx);
        if (i_rst || i_sc) begin
            m_run = 0; m_cnt = 0; m_odd = 0; m_ltx = 0; m_lrx = 0;
            h_slot = '0; h_tx = '0; h_rx = '0;
        end else begin
            h_slot = {h_slot[1:0], hs};
            h_tx   = {h_tx[1:0], ht};
            h_rx   = {h_rx[1:0], hr};
            if (i_ss) begin
                m_run = 1; m_cnt = 0; m_odd = 0;
                m_ltx = clampv(i_atx); m_lrx = clampv(i_arx);
            end else if (m_run) begin
                if (m_cnt == S - 1) begin
                    m_cnt = 0; m_odd = !m_odd;
                    m_ltx = clampv(i_atx); m_lrx = clampv(i_arx);
                end else begin
                    m_cnt++;
                end
            end
        end
    endtask

    task automatic run_n(input int n, input int atx, input int arx);
        for (int i = 0; i < n; i++) step(0, 0, 0, atx, arx);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (2) @(posedge clk);
        // R1: reset then idle without sync
        phase = "R1_reset";
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0);
        run_n(10, 5, 7);
        // R2 R4 R5: zero advance on the boundary
        phase = "R4_R5_zero";
        step(0, 1, 0, 0, 0);
        run_n(40, 0, 0);
        // R6 R8: advances changed mid-slot, latched at next wrap
        phase = "R6_R8_adv";
        run_n(3, 3, 5);
        run_n(60, 3, 5);
        run_n(5, 1, 11);
        run_n(50, 1, 11);
        // R7: advances above one slot are clamped
        phase = "R7_clamp";
        run_n(50, 15, 12);
        // R9: clear in the middle of a pulse, overlap with sync
        phase = "R9_clear";
        while (!(m_run && m_cnt == 1)) step(0, 0, 0, 2, 2);
        step(0, 0, 1, 2, 2);
        run_n(20, 2, 2);
        step(0, 1, 1, 2, 2);
        run_n(10, 2, 2);
        // R10: resync while running
        phase = "R10_resync";
        step(0, 1, 0, 1, 11);
        run_n(17, 1, 11);
        step(0, 1, 0, 4, 0);
        run_n(40, 4, 0);
        // random mix
        phase = "R6_R7_R8_rand";
        begin
            int atx = 0, arx = 0;
            for (int i = 0; i < 3000; i++) begin
                int r = int'($urandom_range(999));
                if ($urandom_range(29) == 0) atx = int'($urandom_range(15));
                if ($urandom_range(29) == 0) arx = int'($urandom_range(15));
                step(r < 3, (r >= 3 && r < 10) || (r >= 990), r >= 985, atx, arx);
            end
        end
        run_n(3, 0, 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog R1 got=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule